// File: doc/BRIEF.md
# Prescaled PWM Timer with Staged Reload

This block produces one pulse-width-modulated output from a system clock. Software writes two 32-bit registers through a simple synchronous write port with a combinational read port. The control word holds the enable, a hold flag, a spare mode flag and a divide exponent. The count word holds a 10-bit period and a 10-bit active time. The clock is divided by a power of two, 2^d, to make ticks. A tick counter runs from zero to period-1. The output is high while the counter is below the active time.

The divide exponent d is built from two fields: a 4-bit coarse field gives d/2 and a single half-step bit gives the low bit of d. The exponent saturates at 24.

Written values go into shadow registers first. They reach the working copy only when no waveform is running, or at the end of a full period. While the hold flag is set they do not move at all. Software can therefore set hold, rewrite period, active time and divider in any order, and then release hold. All three changes take effect together at the next period boundary.

Top module: `pwm_timer`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is low.
- R2: The control word sits at byte offset 0x00 and the count word at 0x04. Control fields: bit 0 enable, bit 4 mode flag, bit 11 hold, bit 15 half-step, bits 19:16 coarse divide. Count fields: period in bits 25:16, active time in bits 9:0. Every field reads back as written. All other bits, and any other offset, read zero. A write to any other offset changes nothing.
- R3: With the counter running, the output period is period·2^d clocks, where d = 2·coarse + half-step.
- R4: Each period starts with the output high, and the output stays high for active·2^d clocks. If the active time is not below the period, the output stays high continuously.
- R5: While the working period or active time is zero, the output stays low even with enable set.
- R6: Clearing enable drives the output low one clock after the write and clears the counter. After enable is set again, the first high phase has its full length.
- R7: While hold is set, writes to the count word and to the divide fields leave the waveform unchanged. After hold is cleared, the staged values apply together from the next period boundary, and the period in progress runs to its old length.
- R8: With hold clear and the output running, a new count word takes effect only at the next period boundary. The period in progress is never cut short.
- R9: The mode flag is a plain storage bit and has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
A faulty prescaler limit or tick counter shows up at the pin within one period, as a high time or period that is not an exact multiple of 2^d. Measuring both lengths for each random setting catches such a fault on the first full cycle. A wrong reload condition shows up at the first boundary after a write: the period in progress comes out shorter than expected, or held values appear early. For this reason the bench times the rise-to-rise interval across each update. A lost enable or zero-field gate shows up on the output after a single clock.

// File: rtl/pwm_pkg.sv
// Package: shared constants for the PWM timer.
// Register offsets and bit positions are fixed because software depends on them.
package pwm_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 10;
    localparam int DIV_MAX  = 24;
    localparam int DIV_W    = $clog2(DIV_MAX + 1);
    localparam int PRE_W    = DIV_MAX;
    localparam int COARSE_W = 4;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;

    // control word bit positions
    localparam int B_EN     = 0;
    localparam int B_MODE   = 4;
    localparam int B_HOLD   = 11;
    localparam int B_HALF   = 15;
    localparam int B_COARSE = 16;
    // count word field positions
    localparam int B_PER    = 16;
    localparam int B_ACT    = 0;

    // Working (active) settings as a single bundle.
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] act;
        logic [DIV_W-1:0] div;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Holds the software-visible registers (the shadow copy) and the working copy.
// The working copy loads from the shadow copy when hold is clear and either no
// waveform is running or the counter is wrapping. Assumes one write per clock
// and a byte address.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wrap,
    output logic              run,
    output pwm_cfg_t          cfg
);
    localparam logic [ADDR_W-1:0] A_CTRL  = OFS_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_COUNT = OFS_COUNT[ADDR_W-1:0];

    logic                en_q, mode_q, hold_q, half_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [CNT_W-1:0]    sh_per, sh_act;
    pwm_cfg_t            cfg_q, sh_cfg;
    logic                sel_ctrl, sel_count, load;
    logic [DIV_W:0]      div_raw;

    assign sel_ctrl  = wr_en && (addr == A_CTRL);
    assign sel_count = wr_en && (addr == A_COUNT);

    // Build the exponent from the coarse field and the half-step bit, saturated at the maximum.
    always_comb begin
        div_raw = {coarse_q, half_q};
        if (div_raw > (DIV_W+1)'(DIV_MAX))
            sh_cfg.div = DIV_W'(DIV_MAX);
        else
            sh_cfg.div = div_raw[DIV_W-1:0];
        sh_cfg.per = sh_per;
        sh_cfg.act = sh_act;
    end

    // Store the control fields on a write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mode_q   <= 1'b0;
            hold_q   <= 1'b0;
            half_q   <= 1'b0;
            coarse_q <= '0;
        end else if (sel_ctrl) begin
            en_q     <= wdata[B_EN];
            mode_q   <= wdata[B_MODE];
            hold_q   <= wdata[B_HOLD];
            half_q   <= wdata[B_HALF];
            coarse_q <= wdata[B_COARSE +: COARSE_W];
        end
    end

    // Store the shadow period and active time on a write to the count offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per <= '0;
            sh_act <= '0;
        end else if (sel_count) begin
            sh_per <= wdata[B_PER +: CNT_W];
            sh_act <= wdata[B_ACT +: CNT_W];
        end
    end

    // Load point: only when hold is clear, and only when idle or at a wrap.
    assign load = !hold_q && (!run || wrap);

    // Copy the shadow settings into the working copy at a load point.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= '0;
        else if (load) cfg_q <= sh_cfg;
    end

    assign cfg = cfg_q;
    assign run = en_q && (cfg_q.per != '0) && (cfg_q.act != '0);

    // Read multiplexer: return the stored fields, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[B_EN]                  = en_q;
            rdata[B_MODE]                = mode_q;
            rdata[B_HOLD]                = hold_q;
            rdata[B_HALF]                = half_q;
            rdata[B_COARSE +: COARSE_W]  = coarse_q;
        end else if (addr == A_COUNT) begin
            rdata[B_PER +: CNT_W] = sh_per;
            rdata[B_ACT +: CNT_W] = sh_act;
        end
    end

    // R7: while held, the working copy must not move
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> $stable(cfg_q));
    // R8: while running, the working copy changes only at a wrap
    a_r8_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(cfg_q));
    // R5: a zero working field never counts as running
    a_r5_zero_not_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.per == '0 || cfg_q.act == '0) |-> !run);
endmodule

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Makes a one-clock tick every 2^div clocks while run is high. The count is
// held at zero while idle, so the first tick after a start comes 2^div clocks
// later. Assumes div <= PRE_W.
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   lim_w;

    // Terminal count for the selected exponent.
    always_comb begin
        lim_w = ((PRE_W+1)'(1) << div) - (PRE_W+1)'(1);
    end

    assign tick = run && (pre_q == lim_w[PRE_W-1:0]);

    // Advance the divide count, restarting at each tick or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // R6: an idle prescaler holds at zero
    a_r6_pre_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
    // R3: with exponent above zero, a tick is never directly followed by another
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Counts prescaled ticks from zero to per-1, reports the wrap, and compares the
// count with the active time to drive the output. Assumes per is nonzero
// whenever run is high.
module pwm_counter
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] act,
    output logic             wrap,
    output logic             pwm_out
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last    = (cnt_q == per - 1'b1);
    assign wrap    = tick && last;
    assign pwm_out = run && (cnt_q < act);

    // Step the counter on each tick, wrap at the period end, clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (wrap)      cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    // R3: a running count always stays below the period
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < per));
    // R4: every period begins in the high phase
    a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && run) |=> (pwm_out || !run));
endmodule

// File: rtl/pwm_timer.sv
// Module: pwm_timer (top)
// Single-channel PWM timer: register file with a staged reload, power-of-two
// prescaler, and a period counter with output compare. Synchronous active-low
// reset. The read port is combinational.
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    logic     run, tick, wrap;
    pwm_cfg_t cfg;

    pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .wrap  (wrap),
        .run   (run),
        .cfg   (cfg)
    );

    pwm_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg.div),
        .tick  (tick)
    );

    pwm_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .per     (cfg.per),
        .act     (cfg.act),
        .wrap    (wrap),
        .pwm_out (pwm_out)
    );

    // R6: whenever enable reads back clear, the output is low
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> !pwm_out);
endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails = 0;
    int ncyc = 0;

    pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", ncyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] ctrl_word(bit en, bit hold, int d, bit mode);
        logic [31:0] w = '0;
        w[0] = en; w[4] = mode; w[11] = hold; w[15] = d[0];
        w[19:16] = 4'(d >> 1);
        return w;
    endfunction

    function automatic logic [31:0] count_word(int per, int act);
        return {6'd0, 10'(per), 6'd0, 10'(act)};
    endfunction

    function automatic int ticks(int n, int d);
        return n << d;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_rise(output int t);
        logic pv = pwm_out;
        int guard = 0;
        forever begin
            @(negedge clk);
            if (pwm_out && !pv) break;
            pv = pwm_out;
            guard++;
            if (guard > 20000) begin
                $display("FAIL no rising edge: actual none expected edge");
                fails++;
                break;
            end
        end
        t = ncyc;
    endtask

    task automatic measure(output int hi, output int per);
        int t0, t1, g;
        wait_rise(t0);
        hi = 0; g = 0;
        while (pwm_out && g < 20000) begin
            hi++; g++;
            @(negedge clk);
        end
        wait_rise(t1);
        per = t1 - t0;
    endtask

    task automatic run_cfg(int per, int act, int d, bit mode);
        wr(3'h0, 32'h0);
        wr(3'h4, count_word(per, act));
        wr(3'h0, ctrl_word(1'b1, 1'b0, d, mode));
    endtask

    initial begin
        int hi, per, t0, t1, lowcnt, highcnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl after reset", 3'h0, 32'h0);
        rd_chk("R1 count after reset", 3'h4, 32'h0);
        chk("R1 output after reset", pwm_out, 0);

        // R2 field map and read-back
        wr(3'h4, 32'hFFFF_FFFF);
        rd_chk("R2 count fields", 3'h4, 32'h03FF_03FF);
        wr(3'h4, 32'h0);
        wr(3'h0, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl fields", 3'h0, 32'h000F_8811);
        wr(3'h6, 32'hFFFF_FFFF);
        rd_chk("R2 other offset reads zero", 3'h6, 32'h0);
        rd_chk("R2 other offset write ignored", 3'h4, 32'h0);
        wr(3'h0, 32'h0);
        rd_chk("R2 ctrl cleared", 3'h0, 32'h0);

        // R3/R4 directed: d = 0 and d = 3
        run_cfg(10, 3, 0, 1'b0);
        measure(hi, per);
        chk("R4 high d=0", hi, ticks(3, 0));
        chk("R3 period d=0", per, ticks(10, 0));
        run_cfg(7, 5, 3, 1'b0);
        measure(hi, per);
        chk("R4 high d=3", hi, ticks(5, 3));
        chk("R3 period d=3", per, ticks(7, 3));

        // R3/R4 random settings
        for (int i = 0; i < 8; i++) begin
            int p = $urandom_range(40, 2);
            int a = $urandom_range(p - 1, 1);
            int d = $urandom_range(4, 0);
            run_cfg(p, a, d, 1'b0);
            measure(hi, per);
            chk($sformatf("R4 high rnd p=%0d a=%0d d=%0d", p, a, d), hi, ticks(a, d));
            chk($sformatf("R3 period rnd p=%0d a=%0d d=%0d", p, a, d), per, ticks(p, d));
        end

        // R4 active >= period: constantly high
        run_cfg(5, 9, 0, 1'b0);
        @(negedge clk);
        highcnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_out) highcnt++;
            @(negedge clk);
        end
        chk("R4 always high when active>=period", highcnt, 40);

        // R5 zero period or zero active keeps output low
        run_cfg(0, 4, 0, 1'b0);
        lowcnt = 0;
        for (int i = 0; i < 60; i++) begin
            if (!pwm_out) lowcnt++;
            @(negedge clk);
        end
        chk("R5 zero period low", lowcnt, 60);
        run_cfg(8, 0, 1, 1'b0);
        lowcnt = 0;
        for (int i = 0; i < 60; i++) begin
            if (!pwm_out) lowcnt++;
            @(negedge clk);
        end
        chk("R5 zero active low", lowcnt, 60);

        // R6 disable drops output next clock; re-enable gives full first high
        run_cfg(12, 6, 1, 1'b0);
        wait_rise(t0);
        @(negedge clk);
        wr(3'h0, ctrl_word(1'b0, 1'b0, 1, 1'b0));
        chk("R6 low after disable", pwm_out, 0);
        repeat (5) @(negedge clk);
        wr(3'h0, ctrl_word(1'b1, 1'b0, 1, 1'b0));
        hi = 0;
        while (pwm_out && hi < 1000) begin
            hi++;
            @(negedge clk);
        end
        chk("R6 first high after re-enable", hi, ticks(6, 1));

        // R8 update while running waits for the boundary
        run_cfg(10, 3, 1, 1'b0);
        wait_rise(t0);
        repeat (3) @(negedge clk);
        wr(3'h4, count_word(4, 1));
        wait_rise(t1);
        chk("R8 old period completes", t1 - t0, ticks(10, 1));
        measure(hi, per);
        chk("R8 new high", hi, ticks(1, 1));
        chk("R8 new period", per, ticks(4, 1));

        // R7 hold stages period, active and divider together
        run_cfg(12, 5, 0, 1'b0);
        wr(3'h0, ctrl_word(1'b1, 1'b1, 0, 1'b0));
        wr(3'h4, count_word(7, 2));
        wr(3'h0, ctrl_word(1'b1, 1'b1, 1, 1'b0));
        measure(hi, per);
        chk("R7 held high unchanged", hi, 5);
        chk("R7 held period unchanged", per, 12);
        wait_rise(t0);
        wr(3'h0, ctrl_word(1'b1, 1'b0, 1, 1'b0));
        wait_rise(t1);
        chk("R7 period at release keeps old length", t1 - t0, 12);
        measure(hi, per);
        chk("R7 staged high applied", hi, ticks(2, 1));
        chk("R7 staged period applied", per, ticks(7, 1));

        // R9 mode flag stored, no effect on waveform
        run_cfg(10, 3, 0, 1'b1);
        rd_chk("R9 mode bit reads back", 3'h0, ctrl_word(1'b1, 1'b0, 0, 1'b1));
        measure(hi, per);
        chk("R9 high unaffected", hi, 3);
        chk("R9 period unaffected", per, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule